// File: doc/BRIEF.md
# Transmit Deferral Timer

This block grants a 10 Mb/s Ethernet transmitter permission to start a new frame once the medium has been quiet for a programmed interval. The interval is counted in byte times of eight bit ticks. Its length is floor((D + 17 + S) / 8) + 2 byte times, where S is an 8-bit defer setting and D is a measured lag in bit times.

In half duplex, the block measures D itself. It counts bit ticks from the cycle in which its own TXEN drops to the cycle in which carrier sense drops, and keeps that value until the next transmission. The interval starts when carrier falls. A rise of carrier or of TXEN withdraws the permission.

In full duplex, carrier sense has no effect. D is taken as zero and the interval runs from the fall of TXEN. Full duplex is selected when either a software bit or a board pin is high.

Top module: `tx_defer_timer`

## Requirements
- R1: After reset `defer_done` is 0 and stays 0 until a complete defer interval has elapsed.
- R2: Full-duplex behaviour applies when `fdx_sw` is 1, when `fdx_pin` is 1, or when both are 1. Half duplex applies only when both are 0.
- R3: In half duplex, a fall of `crs` (1 in one cycle, 0 in the next) starts the interval. A tick in that start cycle is not counted. `defer_done` becomes 1 in the cycle after the tick that completes (floor((D+17+S)/8)+2)*8 ticks. With D=34, S=21 this is 88 ticks. With D=34, S=29 it is 96 ticks.
- R4: D is the number of `bit_tick` cycles strictly between the cycle in which `txen` falls and the cycle in which `crs` falls. If both fall in the same cycle, D is 0.
- R5: The lag count saturates at 255. With S=0 and a saturated lag, the interval is 288 ticks.
- R6: In full duplex, a fall of `txen` starts the interval with D=0, and a tick in that start cycle is not counted. Rises and falls of `crs` neither clear nor restart the interval.
- R7: A rise of `txen` clears `defer_done` in the next cycle and stops the interval, in either mode.
- R8: In half duplex, a rise of `crs` clears `defer_done` in the next cycle and stops the interval.
- R9: In half duplex, a fall of `crs` with no preceding fall of `txen` reuses the last captured D.
- R10: When a clearing event and a starting event fall in the same cycle, the clear wins. No interval starts, and `defer_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per 100 ns bit time |
| txen | input | 1 | Transmit enable of the local transmitter |
| crs | input | 1 | Carrier sense |
| defer_setting | input | 8 | Defer register setting S |
| fdx_sw | input | 1 | Software full-duplex bit |
| fdx_pin | input | 1 | Hardware full-duplex pin |
| defer_done | output | 1 | Permission to assert TXEN |

## Verification
In half duplex, the fall of carrier does two jobs in one cycle: it freezes the lag count and it starts the byte timer from that frozen value. The bench provokes this with a carrier fall after a known number of ticks. It also provokes it with carrier and TXEN falling together, where D must be 0. In both cases it compares the tick count up to permission against the formula. It also makes a TXEN rise coincide with a carrier fall, and checks on every clock, against a behavioural model, that the clear wins and no interval begins.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_COUNT = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;
endpackage

// File: rtl/tdt_edge.sv
module tdt_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = sig[i] & ~st_q.prev[i];
        assign fall[i] = ~sig[i] & st_q.prev[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tdt_lag_meter.sv
module tdt_lag_meter #(
    parameter int LAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             txen_fall,
    input  logic             crs_fall,
    output logic [LAG_W-1:0] lag_sample
);
    localparam logic [LAG_W-1:0] LAG_MAX = '1;

    typedef struct packed {
        logic             active;
        logic [LAG_W-1:0] cnt;
    } lag_st_t;

    lag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (txen_fall) begin
            st_d.cnt    = '0;
            st_d.active = ~crs_fall;
        end else if (st_q.active) begin
            if (crs_fall) begin
                st_d.active = 1'b0;
            end else if (tick && st_q.cnt != LAG_MAX) begin
                st_d.cnt = st_q.cnt + LAG_W'(1);
            end
        end
    end

    // value in force at a carrier fall in this cycle
    assign lag_sample = txen_fall ? '0 : st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tdt_interval_calc.sv
module tdt_interval_calc #(
    parameter int LAG_W         = 8,
    parameter int SET_W         = 8,
    parameter int OFFSET        = 17,
    parameter int EXTRA         = 2,
    parameter int BITS_PER_BYTE = 8,
    parameter int SUM_W         = ((LAG_W > SET_W) ? LAG_W : SET_W) + 2
) (
    input  logic [LAG_W-1:0] lag,
    input  logic [SET_W-1:0] setting,
    output logic [SUM_W-1:0] target_bytes
);
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum          = SUM_W'(lag) + SUM_W'(OFFSET) + SUM_W'(setting);
        target_bytes = SUM_W'(sum / BITS_PER_BYTE) + SUM_W'(EXTRA);
    end
endmodule

// File: rtl/tdt_byte_timer.sv
module tdt_byte_timer
    import tdt_pkg::*;
#(
    parameter int TGT_W         = 10,
    parameter int BITS_PER_BYTE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             clear,
    input  logic [TGT_W-1:0] target,
    output logic             done
);
    localparam int SUB_W = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BITS_PER_BYTE - 1);

    typedef struct packed {
        phase_t           phase;
        logic [SUB_W-1:0] sub;
        logic [TGT_W-1:0] bytes;
        logic [TGT_W-1:0] goal;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.phase = PH_WAIT;
            st_d.sub   = '0;
            st_d.bytes = '0;
        end else if (start) begin
            st_d.phase = PH_COUNT;
            st_d.sub   = '0;
            st_d.bytes = '0;
            st_d.goal  = target;
        end else if (st_q.phase == PH_COUNT && tick) begin
            if (st_q.sub == SUB_LAST) begin
                st_d.sub   = '0;
                st_d.bytes = st_q.bytes + TGT_W'(1);
                if (st_q.bytes + TGT_W'(1) == st_q.goal) begin
                    st_d.phase = PH_DONE;
                end
            end else begin
                st_d.sub = st_q.sub + SUB_W'(1);
            end
        end
    end

    assign done = (st_q.phase == PH_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_WAIT;
            st_q.sub   <= '0;
            st_q.bytes <= '0;
            st_q.goal  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
    parameter int SET_W         = 8,
    parameter int LAG_W         = 8,
    parameter int OFFSET        = 17,
    parameter int EXTRA         = 2,
    parameter int BITS_PER_BYTE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             txen,
    input  logic             crs,
    input  logic [SET_W-1:0] defer_setting,
    input  logic             fdx_sw,
    input  logic             fdx_pin,
    output logic             defer_done
);
    localparam int SUM_W = ((LAG_W > SET_W) ? LAG_W : SET_W) + 2;
    localparam int IDX_TX  = 0;
    localparam int IDX_CRS = 1;

    logic             fdx;
    logic [1:0]       rise, fall;
    logic [LAG_W-1:0] lag_sample, lag_used;
    logic [SUM_W-1:0] target_bytes;
    logic             start_ev, clear_ev;

    tdt_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({crs, txen}),
        .rise (rise),
        .fall (fall)
    );

    tdt_lag_meter #(.LAG_W(LAG_W)) u_lag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .txen_fall (fall[IDX_TX]),
        .crs_fall  (fall[IDX_CRS]),
        .lag_sample(lag_sample)
    );

    always_comb begin
        fdx      = fdx_sw | fdx_pin;
        lag_used = fdx ? '0 : lag_sample;
        start_ev = fdx ? fall[IDX_TX] : fall[IDX_CRS];
        clear_ev = rise[IDX_TX] | (~fdx & rise[IDX_CRS]);
    end

    tdt_interval_calc #(
        .LAG_W        (LAG_W),
        .SET_W        (SET_W),
        .OFFSET       (OFFSET),
        .EXTRA        (EXTRA),
        .BITS_PER_BYTE(BITS_PER_BYTE),
        .SUM_W        (SUM_W)
    ) u_calc (
        .lag         (lag_used),
        .setting     (defer_setting),
        .target_bytes(target_bytes)
    );

    tdt_byte_timer #(
        .TGT_W        (SUM_W),
        .BITS_PER_BYTE(BITS_PER_BYTE)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .start (start_ev),
        .clear (clear_ev),
        .target(target_bytes),
        .done  (defer_done)
    );
endmodule

// File: rtl/tx_defer_timer_chk.sv
module tx_defer_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic txen,
    input logic crs,
    input logic fdx_sw,
    input logic fdx_pin,
    input logic defer_done
);
    assert_txen_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen) |=> !defer_done);

    assert_crs_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fdx_sw && !fdx_pin && $rose(crs)) |=> !defer_done);

    assert_fdx_ignores_crs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((fdx_sw || fdx_pin) && $rose(crs) && $stable(txen) && defer_done) |=> defer_done);

    assert_done_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(defer_done) |-> $past(bit_tick));
endmodule

bind tx_defer_timer tx_defer_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .txen      (txen),
    .crs       (crs),
    .fdx_sw    (fdx_sw),
    .fdx_pin   (fdx_pin),
    .defer_done(defer_done)
);

// File: tb/tx_defer_timer_test.sv
`timescale 1ns/1ps
module tx_defer_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       txen = 1'b0;
    logic       crs = 1'b0;
    logic [7:0] defer_setting = 8'd0;
    logic       fdx_sw = 1'b0;
    logic       fdx_pin = 1'b0;
    logic       defer_done;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tx_defer_timer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .txen         (txen),
        .crs          (crs),
        .defer_setting(defer_setting),
        .fdx_sw       (fdx_sw),
        .fdx_pin      (fdx_pin),
        .defer_done   (defer_done)
    );

    // behavioural reference model, counted in bit ticks
    int m_ptx = 0, m_pcrs = 0, m_meas = 0, m_lag = 0;
    int m_phase = 0, m_bits = 0, m_tgt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ptx = 0; m_pcrs = 0; m_meas = 0; m_lag = 0;
            m_phase = 0; m_bits = 0; m_tgt = 0;
        end else begin
            int tf, tr, cf, cr, fd, dval, st, cl;
            tf = (m_ptx == 1 && txen == 0);
            tr = (m_ptx == 0 && txen == 1);
            cf = (m_pcrs == 1 && crs == 0);
            cr = (m_pcrs == 0 && crs == 1);
            fd = (fdx_sw || fdx_pin);
            dval = fd ? 0 : (tf ? 0 : m_lag);
            if (tf) begin
                m_lag = 0; m_meas = cf ? 0 : 1;
            end else if (m_meas == 1) begin
                if (cf) m_meas = 0;
                else if (bit_tick && m_lag < 255) m_lag = m_lag + 1;
            end
            st = fd ? tf : cf;
            cl = tr || (!fd && cr);
            if (cl) m_phase = 0;
            else if (st) begin
                m_phase = 1; m_bits = 0;
                m_tgt = ((dval + 17 + defer_setting) / 8 + 2) * 8;
            end else if (m_phase == 1 && bit_tick) begin
                m_bits = m_bits + 1;
                if (m_bits == m_tgt) m_phase = 2;
            end
            m_ptx = txen; m_pcrs = crs;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic tk);
        bit_tick = tk;
        @(negedge clk);
        chk(defer_done === (m_phase == 2), cur_req, int'(defer_done), int'(m_phase == 2));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic count_done(input int maxt, input int exp, input string req);
        int n = 0;
        while (defer_done !== 1'b1 && n < maxt) begin
            step(1'b1);
            n++;
            if (n == exp - 1) chk(defer_done === 1'b0, req, int'(defer_done), 0);
        end
        chk(n == exp, req, n, exp);
    endtask

    // own frame in half duplex with a lag of d ticks
    task automatic hdx_frame(input int d);
        txen = 1'b1; idle(2);
        crs = 1'b1;  idle(3);
        txen = 1'b0; idle(1);
        for (int i = 0; i < d; i++) begin step(1'b1); step(1'b0); end
        crs = 1'b0;  idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(defer_done === 1'b0, "R1 in reset", int'(defer_done), 0);
        rst_n = 1'b1;
        cur_req = "R1"; idle(4);
        chk(defer_done === 1'b0, "R1 after reset", int'(defer_done), 0);

        cur_req = "R3"; defer_setting = 8'd21;
        hdx_frame(34);
        count_done(400, 88, "R3 D=34 S=21");

        cur_req = "R7"; txen = 1'b1; step(1'b0);
        chk(defer_done === 1'b0, "R7 txen rise clears", int'(defer_done), 0);
        txen = 1'b0; idle(2);

        cur_req = "R3"; defer_setting = 8'd29;
        hdx_frame(34);
        count_done(400, 96, "R3 D=34 S=29");

        cur_req = "R9"; defer_setting = 8'd21;
        crs = 1'b1; idle(3);
        chk(defer_done === 1'b0, "R8 carrier rise clears", int'(defer_done), 0);
        crs = 1'b0; idle(1);
        count_done(400, 88, "R9 held lag");

        cur_req = "R8"; defer_setting = 8'd0;
        crs = 1'b1; idle(2); crs = 1'b0; idle(1);
        for (int i = 0; i < 20; i++) step(1'b1);
        crs = 1'b1; step(1'b1);
        for (int i = 0; i < 300; i++) step(1'b1);
        chk(defer_done === 1'b0, "R8 carrier high holds off", int'(defer_done), 0);
        crs = 1'b0; idle(1);

        cur_req = "R4"; defer_setting = 8'd7;
        txen = 1'b1; idle(2); crs = 1'b1; idle(2);
        for (int i = 0; i < 10; i++) step(1'b1);
        txen = 1'b0; crs = 1'b0; idle(1);
        count_done(400, 40, "R4 simultaneous fall D=0");

        cur_req = "R5"; defer_setting = 8'd0;
        hdx_frame(300);
        count_done(600, 288, "R5 saturated lag");

        cur_req = "R10"; defer_setting = 8'd0;
        crs = 1'b1; idle(2);
        txen = 1'b1; crs = 1'b0; idle(1);
        txen = 1'b0; step(1'b0);
        for (int i = 0; i < 200; i++) step(1'b1);
        chk(defer_done === 1'b0, "R10 clear wins", int'(defer_done), 0);

        cur_req = "R6"; fdx_pin = 1'b1; defer_setting = 8'd15;
        txen = 1'b1; idle(2); txen = 1'b0; idle(1);
        for (int i = 0; i < 10; i++) step(1'b1);
        crs = 1'b1; step(1'b1);
        for (int i = 0; i < 10; i++) step(1'b1);
        crs = 1'b0; step(1'b1);
        count_done(400, 26, "R6 pin, carrier ignored");
        crs = 1'b1; idle(3);
        chk(defer_done === 1'b1, "R6 carrier rise ignored", int'(defer_done), 1);
        crs = 1'b0; idle(2);

        cur_req = "R2"; fdx_pin = 1'b0; fdx_sw = 1'b1; defer_setting = 8'd0;
        crs = 1'b1;
        txen = 1'b1; idle(2); txen = 1'b0; step(1'b1);
        count_done(400, 32, "R2 software bit");
        crs = 1'b0; idle(2);

        cur_req = "R2"; fdx_pin = 1'b1; defer_setting = 8'd8;
        txen = 1'b1; idle(2); txen = 1'b0; idle(1);
        count_done(400, 40, "R2 both bits");

        fdx_pin = 1'b0; fdx_sw = 1'b0; cur_req = "R7";
        txen = 1'b1; step(1'b1);
        chk(defer_done === 1'b0, "R7 clear", int'(defer_done), 0);
        txen = 1'b0; idle(3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule